// File: doc/BRIEF.md
# Search Result Index Register File

This block holds eight result registers that record where a search matched. Each search command names one destination register. When the search hits and this device wins locally or globally, the matched entry index is written into that register. Before it is stored, the index is aligned to the entry size of the region that matched: the low bit is cleared for double-width entries and the two low bits for quad-width entries. The match array and the cascade arbitration are outside this block. They present a one-cycle result strobe that carries the hit flag, both winner flags, the raw index and the entry-size code.

A register also has a valid flag. The flag is set when this device is the global winner of a hit across a depth cascade, and it changes in no other case except reset. The host later names a register for an indirect read or write. The access is granted on this device, with the stored index as its address, only if that register's valid flag is set. Otherwise it is suppressed, so in a cascade only the device that won carries out the access. A separate read port returns a whole 68-bit register word one cycle after the request.

Top module: `srch_result_regfile`

## Requirements
- R1: Synchronous active-high reset clears every register word to all zeros and drives `ind_go` and `rd_vld` low.
- R2: When `rd_en` is high at a clock edge, `rd_vld` is high after that edge and `rd_data` holds the word of register `rd_sel`. In that word, bits [13:0] are the index, bit 31 is the valid flag, and bits [30:14] and [67:32] are zero.
- R3: A result strobe (`srch_en`) with `srch_hit`=1 and at least one of `srch_lwin` or `srch_gwin` set writes the aligned index into register `srch_dst`.
- R4: A strobe with `srch_hit`=0, or with both winner flags 0, leaves every register unchanged.
- R5: Alignment is set by `srch_esize`. Code 00 (68-bit) stores the index unchanged. Code 01 (136-bit) clears bit 0. Code 10 (272-bit) and the unused code 11 clear bits [1:0].
- R6: The valid flag of the destination becomes 1 only on a hit with `srch_gwin`=1. A hit won only locally updates the index and leaves the valid flag as it was. A set flag stays set until reset.
- R7: When `ind_req` is high at a clock edge, `ind_go` is high after that edge only if register `ind_sel` has its valid flag set. When granted, `ind_addr` carries that register's index and `ind_wr_o` repeats `ind_wr`. When the flag is clear, `ind_go` stays low.
- R8: A search updates only the register named by `srch_dst`. All other registers keep their contents.
- R9: A read or indirect request in the same cycle as a search to the same register sees the contents from before that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srch_en | input | 1 | Search result strobe, one cycle |
| srch_dst | input | 3 | Destination register number |
| srch_hit | input | 1 | Search matched |
| srch_lwin | input | 1 | Device is the local winner |
| srch_gwin | input | 1 | Device is the global winner in the cascade |
| srch_index | input | 14 | Raw matched 68-bit entry index |
| srch_esize | input | 2 | Entry-size code of the matching region |
| rd_en | input | 1 | Register word read request |
| rd_sel | input | 3 | Register to read |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 68 | Register word |
| ind_req | input | 1 | Indirect access request |
| ind_sel | input | 3 | Register providing the indirect address |
| ind_wr | input | 1 | Access is a write (1) or read (0) |
| ind_go | output | 1 | Access granted on this device |
| ind_addr | output | 14 | Index used as the access address |
| ind_wr_o | output | 1 | Direction of the granted access |

## Verification
The bench targets the alignment codes, including the unused code 11. An aligner that decoded code 11 as 68-bit would return the low bits unchanged. It also checks that a local-only win updates the index but never the valid flag. A design that tied the flag to any win would then grant indirect accesses on a device that lost the cascade. Misses, hits with no winner, a valid flag that must survive later local wins, and same-cycle search-and-read on one register are all compared against a bench-side model. A wrong write decode would show up as a changed neighbour register or as a read that returns the new value too early.

// File: rtl/srr_pkg.sv
package srr_pkg;
  typedef enum logic [1:0] {
    ESZ_SINGLE = 2'b00,
    ESZ_DOUBLE = 2'b01,
    ESZ_QUAD   = 2'b10,
    ESZ_UNUSED = 2'b11
  } esize_e;
endpackage

// File: rtl/srr_align.sv
module srr_align #(
  parameter int IDX_W = 14
) (
  input  logic [IDX_W-1:0] idx_in,
  input  logic [1:0]       esize,
  output logic [IDX_W-1:0] idx_out
);
  import srr_pkg::*;

  localparam int LOW_KEEP = IDX_W - 2;

  always_comb begin
    unique case (esize_e'(esize))
      ESZ_SINGLE: idx_out = idx_in;
      ESZ_DOUBLE: idx_out = {idx_in[IDX_W-1:1], 1'b0};
      default:    idx_out = {idx_in[IDX_W-1:2], 2'b00};
    endcase
  end

  // R5: any wide entry code yields an even index, upper bits preserved
  always_comb begin
    if (esize != 2'b00) begin
      assert (idx_out[0] == 1'b0);
      assert (idx_out[IDX_W-1:2] == idx_in[LOW_KEEP+1:2]);
    end
  end
endmodule

// File: rtl/srr_update.sv
module srr_update #(
  parameter int NUM_REGS = 8,
  parameter int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic                srch_en,
  input  logic [SEL_W-1:0]    srch_dst,
  input  logic                srch_hit,
  input  logic                srch_lwin,
  input  logic                srch_gwin,
  output logic [NUM_REGS-1:0] idx_we,
  output logic [NUM_REGS-1:0] val_set
);
  logic take_idx;
  logic take_val;

  assign take_idx = srch_en & srch_hit & (srch_lwin | srch_gwin);
  assign take_val = srch_en & srch_hit & srch_gwin;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign idx_we[g]  = take_idx & (srch_dst == SEL_W'(g));
    assign val_set[g] = take_val & (srch_dst == SEL_W'(g));
  end

  // R8: at most one register written; R6: valid set only with an index write
  always_comb begin
    assert ($onehot0(idx_we));
    assert ((val_set & ~idx_we) == '0);
  end
endmodule

// File: rtl/srr_store.sv
module srr_store #(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 14
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_REGS-1:0]            idx_we,
  input  logic [NUM_REGS-1:0]            val_set,
  input  logic [IDX_W-1:0]               idx_wdata,
  output logic [NUM_REGS-1:0][IDX_W-1:0] idx_q,
  output logic [NUM_REGS-1:0]            val_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        idx_q[g] <= '0;
        val_q[g] <= 1'b0;
      end else begin
        if (idx_we[g])  idx_q[g] <= idx_wdata;
        if (val_set[g]) val_q[g] <= 1'b1;
      end
    end

    p_idx_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !idx_we[g] |=> $stable(idx_q[g]));
    p_valid_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      val_q[g] |=> val_q[g]);
    p_valid_needs_win_r6: assert property (@(posedge clk) disable iff (rst)
      (!val_set[g] && !val_q[g]) |=> !val_q[g]);
  end
endmodule

// File: rtl/srr_access.sv
module srr_access #(
  parameter int NUM_REGS  = 8,
  parameter int IDX_W     = 14,
  parameter int REG_W     = 68,
  parameter int VALID_POS = 31,
  parameter int SEL_W     = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_REGS-1:0][IDX_W-1:0] idx_q,
  input  logic [NUM_REGS-1:0]            val_q,
  input  logic                           rd_en,
  input  logic [SEL_W-1:0]               rd_sel,
  output logic                           rd_vld,
  output logic [REG_W-1:0]               rd_data,
  input  logic                           ind_req,
  input  logic [SEL_W-1:0]               ind_sel,
  input  logic                           ind_wr,
  output logic                           ind_go,
  output logic [IDX_W-1:0]               ind_addr,
  output logic                           ind_wr_o
);
  logic [REG_W-1:0] word_sel;

  always_comb begin
    word_sel = '0;
    word_sel[IDX_W-1:0] = idx_q[rd_sel];
    word_sel[VALID_POS] = val_q[rd_sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld   <= 1'b0;
      rd_data  <= '0;
      ind_go   <= 1'b0;
      ind_addr <= '0;
      ind_wr_o <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_data <= word_sel;
      ind_go <= ind_req & val_q[ind_sel];
      if (ind_req) begin
        ind_addr <= idx_q[ind_sel];
        ind_wr_o <= ind_wr;
      end
    end
  end

  p_rd_follows_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_vld);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> (rd_data[REG_W-1:VALID_POS+1] == '0 &&
                rd_data[VALID_POS-1:IDX_W] == '0));
  p_go_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
    (ind_req && !val_q[ind_sel]) |=> !ind_go);
  p_go_needs_req_r7: assert property (@(posedge clk) disable iff (rst)
    !ind_req |=> !ind_go);
endmodule

// File: rtl/srch_result_regfile.sv
module srch_result_regfile #(
  parameter int NUM_REGS  = 8,
  parameter int IDX_W     = 14,
  parameter int REG_W     = 68,
  parameter int VALID_POS = 31,
  localparam int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srch_en,
  input  logic [SEL_W-1:0] srch_dst,
  input  logic             srch_hit,
  input  logic             srch_lwin,
  input  logic             srch_gwin,
  input  logic [IDX_W-1:0] srch_index,
  input  logic [1:0]       srch_esize,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_sel,
  output logic             rd_vld,
  output logic [REG_W-1:0] rd_data,
  input  logic             ind_req,
  input  logic [SEL_W-1:0] ind_sel,
  input  logic             ind_wr,
  output logic             ind_go,
  output logic [IDX_W-1:0] ind_addr,
  output logic             ind_wr_o
);
  logic [IDX_W-1:0]               idx_aligned;
  logic [NUM_REGS-1:0]            idx_we;
  logic [NUM_REGS-1:0]            val_set;
  logic [NUM_REGS-1:0][IDX_W-1:0] idx_q;
  logic [NUM_REGS-1:0]            val_q;

  srr_align #(.IDX_W(IDX_W)) u_align (
    .idx_in (srch_index),
    .esize  (srch_esize),
    .idx_out(idx_aligned)
  );

  srr_update #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_update (
    .srch_en  (srch_en),
    .srch_dst (srch_dst),
    .srch_hit (srch_hit),
    .srch_lwin(srch_lwin),
    .srch_gwin(srch_gwin),
    .idx_we   (idx_we),
    .val_set  (val_set)
  );

  srr_store #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .idx_we   (idx_we),
    .val_set  (val_set),
    .idx_wdata(idx_aligned),
    .idx_q    (idx_q),
    .val_q    (val_q)
  );

  srr_access #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .REG_W(REG_W),
               .VALID_POS(VALID_POS), .SEL_W(SEL_W)) u_access (
    .clk     (clk),
    .rst     (rst),
    .idx_q   (idx_q),
    .val_q   (val_q),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .rd_vld  (rd_vld),
    .rd_data (rd_data),
    .ind_req (ind_req),
    .ind_sel (ind_sel),
    .ind_wr  (ind_wr),
    .ind_go  (ind_go),
    .ind_addr(ind_addr),
    .ind_wr_o(ind_wr_o)
  );
endmodule

// File: tb/srch_result_regfile_bench.sv
module srch_result_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        srch_en = 0, srch_hit = 0, srch_lwin = 0, srch_gwin = 0;
  logic [2:0]  srch_dst = 0, rd_sel = 0, ind_sel = 0;
  logic [13:0] srch_index = 0;
  logic [1:0]  srch_esize = 0;
  logic        rd_en = 0, ind_req = 0, ind_wr = 0;
  logic        rd_vld, ind_go, ind_wr_o;
  logic [67:0] rd_data;
  logic [13:0] ind_addr;

  int checks = 0;
  int fails  = 0;

  logic [13:0] m_idx [8];
  logic        m_val [8];
  logic [67:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  srch_result_regfile u_srch_result_regfile (
    .clk(clk), .rst(rst), .srch_en(srch_en), .srch_dst(srch_dst),
    .srch_hit(srch_hit), .srch_lwin(srch_lwin), .srch_gwin(srch_gwin),
    .srch_index(srch_index), .srch_esize(srch_esize),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_vld(rd_vld), .rd_data(rd_data),
    .ind_req(ind_req), .ind_sel(ind_sel), .ind_wr(ind_wr),
    .ind_go(ind_go), .ind_addr(ind_addr), .ind_wr_o(ind_wr_o)
  );

  function automatic logic [67:0] model_word(int r);
    logic [67:0] w = '0;
    w[13:0] = m_idx[r];
    w[31]   = m_val[r];
    return w;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 8; i++) begin
      m_idx[i] = '0;
      m_val[i] = 1'b0;
    end
  endfunction

  task automatic check(string req, logic [67:0] act, logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read words as the design delivers them
  always @(negedge clk) begin
    if (!rst && rd_vld) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected rd_vld", 68'd1, 68'd0);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic push_read(int r, string req);
    exp_q.push_back(model_word(r));
    tag_q.push_back(req);
  endtask

  task automatic do_read(int r, string req);
    @(negedge clk);
    rd_en = 1; rd_sel = 3'(r);
    push_read(r, req);
    @(negedge clk);
    rd_en = 0;
  endtask

  // search strobe; optional same-cycle read of the destination (R9)
  task automatic do_search(int dst, bit hit, bit lw, bit gw, logic [13:0] idx,
                           logic [1:0] es, bit rd_same);
    logic [13:0] al;
    @(negedge clk);
    srch_en = 1; srch_dst = 3'(dst); srch_hit = hit; srch_lwin = lw;
    srch_gwin = gw; srch_index = idx; srch_esize = es;
    if (rd_same) begin
      rd_en = 1; rd_sel = 3'(dst);
      push_read(dst, "R9 same-cycle read sees old word");
    end
    case (es)
      2'b00:   al = idx;
      2'b01:   al = idx & 14'h3FFE;
      default: al = idx & 14'h3FFC;
    endcase
    if (hit && (lw || gw)) m_idx[dst] = al;
    if (hit && gw) m_val[dst] = 1'b1;
    @(negedge clk);
    srch_en = 0; rd_en = 0;
  endtask

  task automatic do_ind(int r, bit wr, string req);
    @(negedge clk);
    ind_req = 1; ind_sel = 3'(r); ind_wr = wr;
    @(negedge clk);
    ind_req = 0;
    check(req, 68'(ind_go), 68'(m_val[r]));
    if (m_val[r]) begin
      check({req, " addr"}, 68'(ind_addr), 68'(m_idx[r]));
      check({req, " dir"}, 68'(ind_wr_o), 68'(wr));
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    check("R1 ind_go low in reset", 68'(ind_go), 68'd0);
    check("R1 rd_vld low in reset", 68'(rd_vld), 68'd0);
    rst = 0;
    model_reset();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    apply_reset();
    for (int r = 0; r < 8; r++) do_read(r, "R1 reset word zero");
    do_ind(0, 1'b0, "R1 R7 no grant after reset");

    do_search(3, 1, 1, 0, 14'h1235, 2'b00, 0);
    do_read(3, "R3 local win stores index, R6 valid stays 0");
    do_ind(3, 1'b1, "R7 suppressed without valid");

    do_search(5, 1, 0, 1, 14'h0A57, 2'b01, 0);
    do_read(5, "R5 136-bit clears bit0, R6 global sets valid");
    do_ind(5, 1'b1, "R7 granted write");
    do_ind(5, 1'b0, "R7 granted read");

    do_search(0, 1, 1, 1, 14'h3FFF, 2'b10, 0);
    do_read(0, "R5 272-bit clears bits 1:0");
    do_search(1, 1, 1, 0, 14'h0007, 2'b11, 0);
    do_read(1, "R5 code 11 clears bits 1:0");

    do_search(5, 0, 1, 1, 14'h0000, 2'b00, 0);
    do_read(5, "R4 miss leaves register");
    do_search(5, 1, 0, 0, 14'h0123, 2'b00, 0);
    do_read(5, "R4 no-winner hit leaves register");

    do_search(5, 1, 1, 0, 14'h0100, 2'b00, 0);
    do_read(5, "R6 local win keeps valid set");
    do_ind(5, 1'b0, "R7 grant uses new index");

    for (int r = 0; r < 8; r++) do_read(r, "R8 other registers untouched");

    do_search(2, 1, 0, 1, 14'h2AAA, 2'b00, 1);
    do_read(2, "R9 new word visible next cycle");
    do_ind(2, 1'b1, "R7 grant after global win");

    do_search(7, 1, 0, 1, 14'h1111, 2'b00, 0);
    apply_reset();
    do_read(7, "R1 reset clears written register");
    do_ind(7, 1'b0, "R1 R7 reset clears valid");

    repeat (3) @(negedge clk);
    check("R2 no reads left pending", 68'(exp_q.size()), 68'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule